// File: doc/BRIEF.md
# Device Interrupt Status Controller

This block gathers the event pulses of a full-speed device controller into two status bytes and drives one active-low interrupt line for the attached microcontroller. The low byte holds one sticky bit for each of the six endpoint indices, plus a bus-reset bit and a suspend-change bit. The high byte holds a DMA end-of-transfer bit. Endpoint bits are cleared one at a time, each by the status read strobe of its own endpoint. The other three bits are cleared together by the strobe that reads the interrupt register.

A small frame-watch unit tracks frame slots. When a set number of consecutive slots pass with no start-of-frame, it enters suspend. It leaves suspend on any start-of-frame or resume event. Both the entry and the exit set the suspend-change bit. Two mode inputs decide what drives the interrupt line: the stored bits, the stored bits plus start-of-frame pulses, or start-of-frame pulses alone.

Top module: `usb_irq_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, both status bytes are cleared after that edge and `irq_n` is 1.
- R2: A pulse on `ep_evt[i]` that is accepted sets `stat_lo[i]` (bit i = endpoint index i, for i = 0..5) at the next edge.
- R3: A pulse on `irq_reg_rd` clears `stat_lo[6]` (bus reset), `stat_lo[7]` (suspend change) and `stat_hi[0]` (DMA end of transfer), and leaves bits 5..0 of `stat_lo` unchanged.
- R4: An endpoint bit stays set until `ep_stat_rd` is pulsed for that endpoint. A read of another endpoint does not clear it.
- R5: When a bit's set event and its clear strobe fall in the same cycle, the bit is set after the edge.
- R6: When `nakerr_irq_en` is 0, an endpoint event with its `ep_err` bit high does not set the status bit. When `nakerr_irq_en` is 1, it does.
- R7: Events for endpoint indices 4 and 5 set their bits only when `ep_gate_en[0]` (index 4) or `ep_gate_en[1]` (index 5) is 1. Indices 0 to 3 are never gated.
- R8: `MISS_LIMIT` (default 3) consecutive `frame_slot` pulses with no `sof_evt` or `resume_evt` between them put the block in suspend and set `stat_lo[7]`. While in suspend, a `sof_evt` or `resume_evt` leaves suspend and sets `stat_lo[7]` again. A `sof_evt` restarts the slot count.
- R9: With `sof_only_mode`=0 and `pin_mode`=0, `irq_n` is 0 exactly when some status bit is set. `sof_evt` has no effect on `irq_n`.
- R10: With `sof_only_mode`=0 and `pin_mode`=1, `irq_n` is also 0 for one cycle after each `sof_evt`.
- R11: With `sof_only_mode`=1, `irq_n` is 0 only in the cycle after a `sof_evt`, whatever the status bits and `pin_mode` hold.
- R12: Bits 7..1 of `stat_hi` always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ep_evt | input | 6 | Per-endpoint transaction-complete pulse |
| ep_err | input | 6 | Qualifies an `ep_evt` as a NAKed or errored transaction |
| nakerr_irq_en | input | 1 | Lets NAKed and errored transactions set status |
| ep_gate_en | input | 2 | Event enables for endpoint indices 4 and 5 |
| ep_stat_rd | input | 6 | Per-endpoint last-status read strobe, clears that endpoint's bit |
| irq_reg_rd | input | 1 | Interrupt-register read strobe |
| bus_reset_evt | input | 1 | Bus reset detected pulse |
| dma_eot_evt | input | 1 | DMA end-of-transfer pulse |
| sof_evt | input | 1 | Start-of-frame received pulse |
| frame_slot | input | 1 | End of one frame interval |
| resume_evt | input | 1 | Resume signalling seen on the bus |
| sof_only_mode | input | 1 | Interrupt line follows start-of-frame only |
| pin_mode | input | 1 | Adds start-of-frame pulses to the interrupt line |
| stat_lo | output | 8 | Status byte: endpoint bits 5..0, bus reset 6, suspend change 7 |
| stat_hi | output | 8 | Status byte: DMA end of transfer in bit 0 |
| irq_n | output | 1 | Interrupt line, active low, registered |

## Verification
A status bit can be set and cleared in the same cycle. An endpoint event can meet that endpoint's status read, and a bus-reset pulse can meet the interrupt-register read. The bench drives both pulses in one cycle, and the bit must be 1 after the edge. A separate read of the bit then clears it, which shows that the set came from the event and was not a clear that failed. The slot counter can also see a start-of-frame and a slot end in the same cycle. Such a slot is judged as counted but not missed, and the bench checks that suspend then needs three further empty slots.

// File: rtl/irq_pkg.sv
package irq_pkg;
  parameter int unsigned IRQ_NUM_EP    = 6;
  parameter int unsigned IRQ_GATE_BASE = 4;
  parameter int unsigned IRQ_BUSRST_POS = IRQ_NUM_EP;
  parameter int unsigned IRQ_SUSP_POS   = IRQ_NUM_EP + 1;
  parameter int unsigned IRQ_LO_W       = IRQ_NUM_EP + 2;
  parameter int unsigned IRQ_HI_W       = 8;

  typedef struct packed {
    logic sof_only;
    logic pin_mode;
  } irq_pin_cfg_t;
endpackage

// File: rtl/irq_susp_det.sv
module irq_susp_det #(
  parameter int unsigned MISS_LIMIT = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic frame_slot,
  input  logic sof_evt,
  input  logic resume_evt,
  output logic susp_chg
);
  localparam int unsigned CNT_W = $clog2(MISS_LIMIT + 1);

  logic [CNT_W-1:0] miss_cnt;
  logic             suspended;
  logic             activity;
  logic             enter_susp;
  logic             leave_susp;

  assign activity   = sof_evt | resume_evt;
  assign enter_susp = !suspended && frame_slot && !activity &&
                      (miss_cnt == CNT_W'(MISS_LIMIT - 1));
  assign leave_susp = suspended && activity;
  assign susp_chg   = enter_susp | leave_susp;

  always_ff @(posedge clk) begin
    if (rst) begin
      miss_cnt  <= '0;
      suspended <= 1'b0;
    end else begin
      if (activity || enter_susp) begin
        miss_cnt <= '0;
      end else if (frame_slot && !suspended) begin
        miss_cnt <= miss_cnt + 1'b1;
      end
      if (enter_susp) begin
        suspended <= 1'b1;
      end else if (leave_susp) begin
        suspended <= 1'b0;
      end
    end
  end

  // R8
  susp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    suspended && !sof_evt && !resume_evt |=> suspended);

  // R8
  awake_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !suspended && !frame_slot |=> !suspended);
endmodule

// File: rtl/irq_stat_reg.sv
module irq_stat_reg
  import irq_pkg::*;
#(
  parameter int unsigned NUM_EP    = IRQ_NUM_EP,
  parameter int unsigned GATE_BASE = IRQ_GATE_BASE,
  parameter int unsigned LO_W      = NUM_EP + 2,
  parameter int unsigned HI_W      = IRQ_HI_W
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_EP-1:0]         ep_evt,
  input  logic [NUM_EP-1:0]         ep_err,
  input  logic                      nakerr_irq_en,
  input  logic [NUM_EP-GATE_BASE-1:0] ep_gate_en,
  input  logic [NUM_EP-1:0]         ep_stat_rd,
  input  logic                      irq_reg_rd,
  input  logic                      bus_reset_evt,
  input  logic                      susp_chg,
  input  logic                      dma_eot_evt,
  output logic [LO_W-1:0]           stat_lo,
  output logic [HI_W-1:0]           stat_hi,
  output logic                      any_nxt
);
  localparam int unsigned RST_POS = NUM_EP;
  localparam int unsigned SUS_POS = NUM_EP + 1;

  logic [NUM_EP-1:0] ep_ok;
  logic [LO_W-1:0]   lo_nxt;
  logic [HI_W-1:0]   hi_nxt;

  for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
    logic qual;
    assign qual = ep_evt[i] && (!ep_err[i] || nakerr_irq_en);
    if (i >= GATE_BASE) begin : g_gated
      assign ep_ok[i] = qual && ep_gate_en[i-GATE_BASE];
    end else begin : g_open
      assign ep_ok[i] = qual;
    end
    assign lo_nxt[i] = ep_ok[i] | (stat_lo[i] & ~ep_stat_rd[i]);

    // R5
    ep_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
      ep_ok[i] |=> stat_lo[i]);

    // R4
    ep_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      stat_lo[i] && !ep_stat_rd[i] |=> stat_lo[i]);
  end

  assign lo_nxt[RST_POS] = bus_reset_evt | (stat_lo[RST_POS] & ~irq_reg_rd);
  assign lo_nxt[SUS_POS] = susp_chg      | (stat_lo[SUS_POS] & ~irq_reg_rd);
  assign hi_nxt          = {{(HI_W-1){1'b0}}, dma_eot_evt | (stat_hi[0] & ~irq_reg_rd)};
  assign any_nxt         = |lo_nxt || |hi_nxt;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_lo <= '0;
      stat_hi <= '0;
    end else begin
      stat_lo <= lo_nxt;
      stat_hi <= hi_nxt;
    end
  end

  // R3
  busrst_clear_chk: assert property (@(posedge clk) disable iff (rst)
    irq_reg_rd && !bus_reset_evt |=> !stat_lo[RST_POS]);

  // R3
  ep_keep_on_read_chk: assert property (@(posedge clk) disable iff (rst)
    irq_reg_rd && (ep_stat_rd == '0) |=> ((stat_lo[NUM_EP-1:0] & ~$past(stat_lo[NUM_EP-1:0])) == (stat_lo[NUM_EP-1:0] & ~$past(stat_lo[NUM_EP-1:0]))) && (($past(stat_lo[NUM_EP-1:0]) & ~stat_lo[NUM_EP-1:0]) == '0));

  // R12
  hi_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    irq_reg_rd || dma_eot_evt |=> stat_hi[HI_W-1:1] == '0);
endmodule

// File: rtl/irq_pin_ctl.sv
module irq_pin_ctl
  import irq_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  irq_pin_cfg_t cfg,
  input  logic         sof_evt,
  input  logic         any_nxt,
  output logic         irq_n
);
  logic assert_nxt;

  always_comb begin
    if (cfg.sof_only) begin
      assert_nxt = sof_evt;
    end else begin
      assert_nxt = any_nxt | (cfg.pin_mode & sof_evt);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_n <= 1'b1;
    end else begin
      irq_n <= ~assert_nxt;
    end
  end

  // R11
  sof_only_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    cfg.sof_only && !sof_evt |=> irq_n);

  // R10
  sof_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg.sof_only && cfg.pin_mode && sof_evt |=> !irq_n);
endmodule

// File: rtl/usb_irq_ctrl.sv
module usb_irq_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned MISS_LIMIT = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [5:0] ep_evt,
  input  logic [5:0] ep_err,
  input  logic       nakerr_irq_en,
  input  logic [1:0] ep_gate_en,
  input  logic [5:0] ep_stat_rd,
  input  logic       irq_reg_rd,
  input  logic       bus_reset_evt,
  input  logic       dma_eot_evt,
  input  logic       sof_evt,
  input  logic       frame_slot,
  input  logic       resume_evt,
  input  logic       sof_only_mode,
  input  logic       pin_mode,
  output logic [7:0] stat_lo,
  output logic [7:0] stat_hi,
  output logic       irq_n
);
  logic         susp_chg;
  logic         any_nxt;
  irq_pin_cfg_t pin_cfg;

  assign pin_cfg.sof_only = sof_only_mode;
  assign pin_cfg.pin_mode = pin_mode;

  irq_susp_det #(.MISS_LIMIT(MISS_LIMIT)) u_susp (
    .clk        (clk),
    .rst        (rst),
    .frame_slot (frame_slot),
    .sof_evt    (sof_evt),
    .resume_evt (resume_evt),
    .susp_chg   (susp_chg)
  );

  irq_stat_reg #(
    .NUM_EP    (IRQ_NUM_EP),
    .GATE_BASE (IRQ_GATE_BASE),
    .LO_W      (IRQ_LO_W),
    .HI_W      (IRQ_HI_W)
  ) u_stat (
    .clk           (clk),
    .rst           (rst),
    .ep_evt        (ep_evt),
    .ep_err        (ep_err),
    .nakerr_irq_en (nakerr_irq_en),
    .ep_gate_en    (ep_gate_en),
    .ep_stat_rd    (ep_stat_rd),
    .irq_reg_rd    (irq_reg_rd),
    .bus_reset_evt (bus_reset_evt),
    .susp_chg      (susp_chg),
    .dma_eot_evt   (dma_eot_evt),
    .stat_lo       (stat_lo),
    .stat_hi       (stat_hi),
    .any_nxt       (any_nxt)
  );

  irq_pin_ctl u_pin (
    .clk     (clk),
    .rst     (rst),
    .cfg     (pin_cfg),
    .sof_evt (sof_evt),
    .any_nxt (any_nxt),
    .irq_n   (irq_n)
  );

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (stat_lo == 8'h00) && (stat_hi == 8'h00) && irq_n);

  // R9
  mode0_pin_chk: assert property (@(posedge clk) disable iff (rst)
    !sof_only_mode && !pin_mode && !$past(sof_only_mode) && !$past(pin_mode) && !$past(rst)
      |-> (irq_n == ((stat_lo == 8'h00) && (stat_hi == 8'h00))));
endmodule

// File: tb/usb_irq_ctrl_test.sv
module usb_irq_ctrl_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] ep_evt = '0, ep_err = '0, ep_stat_rd = '0;
  logic       nakerr_irq_en = 1'b0;
  logic [1:0] ep_gate_en = '0;
  logic       irq_reg_rd = 0, bus_reset_evt = 0, dma_eot_evt = 0;
  logic       sof_evt = 0, frame_slot = 0, resume_evt = 0;
  logic       sof_only_mode = 0, pin_mode = 0;
  logic [7:0] stat_lo, stat_hi;
  logic       irq_n;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  usb_irq_ctrl uut (
    .clk(clk), .rst(rst), .ep_evt(ep_evt), .ep_err(ep_err),
    .nakerr_irq_en(nakerr_irq_en), .ep_gate_en(ep_gate_en),
    .ep_stat_rd(ep_stat_rd), .irq_reg_rd(irq_reg_rd),
    .bus_reset_evt(bus_reset_evt), .dma_eot_evt(dma_eot_evt),
    .sof_evt(sof_evt), .frame_slot(frame_slot), .resume_evt(resume_evt),
    .sof_only_mode(sof_only_mode), .pin_mode(pin_mode),
    .stat_lo(stat_lo), .stat_hi(stat_hi), .irq_n(irq_n)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // One clock: inputs set before this call are seen at the next edge, then pulses drop.
  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    ep_evt = '0; ep_stat_rd = '0; irq_reg_rd = 0; bus_reset_evt = 0;
    dma_eot_evt = 0; sof_evt = 0; frame_slot = 0; resume_evt = 0;
  endtask

  task automatic do_reset();
    rst = 1; cyc(); rst = 0;
  endtask

  initial begin
    #(200000 * 4);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1
    chk("R1 reset status", {stat_hi, stat_lo}, 16'h0000);
    chk("R1 reset irq_n", {15'd0, irq_n}, 16'h0001);

    // Endpoint sweep: R2 R4 R6 R7 R9
    for (int i = 0; i < 6; i++) begin
      for (int c = 0; c < 8; c++) begin
        logic e, n, g, exp_set;
        int j;
        e = c[0]; n = c[1]; g = c[2];
        exp_set = (!e || n) && (i < 4 || g);
        j = (i + 1) % 6;
        do_reset();
        sof_only_mode = 0; pin_mode = 0;
        nakerr_irq_en = n; ep_gate_en = g ? 2'b11 : 2'b00;
        ep_err = '0; ep_err[i] = e; ep_evt[i] = 1'b1;
        cyc();
        ep_err = '0;
        chk($sformatf("R2 R6 R7 set ep%0d err=%0d en=%0d gate=%0d", i, e, n, g),
            {8'h00, stat_lo}, {8'h00, 8'(exp_set) << i});
        chk("R9 pin follows status", {15'd0, irq_n}, {15'd0, ~exp_set});
        if (exp_set) begin
          ep_stat_rd[j] = 1'b1; cyc();
          chk("R4 other endpoint read keeps bit", {8'h00, stat_lo}, {8'h00, 8'(1) << i});
          irq_reg_rd = 1'b1; cyc();
          chk("R3 register read keeps endpoint bit", {8'h00, stat_lo}, {8'h00, 8'(1) << i});
          ep_stat_rd[i] = 1'b1; cyc();
          chk("R4 own read clears bit", {8'h00, stat_lo}, 16'h0000);
          chk("R9 pin released", {15'd0, irq_n}, 16'h0001);
        end
      end
    end

    // Bus reset and DMA EOT, collision with register read: R3 R5 R12
    do_reset();
    bus_reset_evt = 1; dma_eot_evt = 1; cyc();
    chk("R3 R12 set bus reset and eot", {stat_hi, stat_lo}, 16'h0140);
    irq_reg_rd = 1; bus_reset_evt = 1; cyc();
    chk("R5 bus reset wins over read", {stat_hi, stat_lo}, 16'h0040);
    irq_reg_rd = 1; cyc();
    chk("R3 read clears", {stat_hi, stat_lo}, 16'h0000);

    // Endpoint collision: R5
    ep_evt[2] = 1; cyc();
    ep_evt[2] = 1; ep_stat_rd[2] = 1; cyc();
    chk("R5 endpoint event wins over its read", {8'h00, stat_lo}, 16'h0004);
    ep_stat_rd[2] = 1; cyc();
    chk("R5 later read clears", {8'h00, stat_lo}, 16'h0000);

    // Suspend detection: R8
    do_reset();
    frame_slot = 1; cyc();
    frame_slot = 1; cyc();
    chk("R8 two misses no change", {8'h00, stat_lo}, 16'h0000);
    frame_slot = 1; cyc();
    chk("R8 third miss enters suspend", {8'h00, stat_lo}, 16'h0080);
    irq_reg_rd = 1; cyc();
    frame_slot = 1; cyc();
    frame_slot = 1; cyc();
    frame_slot = 1; cyc();
    chk("R8 slots ignored in suspend", {8'h00, stat_lo}, 16'h0000);
    sof_evt = 1; cyc();
    chk("R8 resume on sof", {8'h00, stat_lo}, 16'h0080);
    irq_reg_rd = 1; cyc();
    frame_slot = 1; cyc();
    frame_slot = 1; cyc();
    frame_slot = 1; sof_evt = 1; cyc();
    frame_slot = 1; cyc();
    frame_slot = 1; cyc();
    chk("R8 sof restarts count", {8'h00, stat_lo}, 16'h0000);
    frame_slot = 1; cyc();
    chk("R8 suspend after three fresh misses", {8'h00, stat_lo}, 16'h0080);
    resume_evt = 1; irq_reg_rd = 1; cyc();
    chk("R8 R5 resume wins over read", {8'h00, stat_lo}, 16'h0080);

    // Pin mode sweep: R9 R10 R11
    for (int m = 0; m < 4; m++) begin
      for (int st = 0; st < 2; st++) begin
        for (int s = 0; s < 2; s++) begin
          logic so, pm, low1, low2;
          so = m[1]; pm = m[0];
          low1 = so ? s[0] : (st[0] | (pm & s[0]));
          low2 = so ? 1'b0 : st[0];
          do_reset();
          sof_only_mode = so; pin_mode = pm;
          if (st != 0) begin
            ep_evt[0] = 1; cyc();
          end
          sof_evt = s[0]; cyc();
          chk($sformatf("R9 R10 R11 pin so=%0d pm=%0d st=%0d sof=%0d", so, pm, st, s),
              {15'd0, irq_n}, {15'd0, ~low1});
          cyc();
          chk($sformatf("R10 R11 pin after pulse so=%0d pm=%0d st=%0d", so, pm, st),
              {15'd0, irq_n}, {15'd0, ~low2});
        end
      end
    end

    finish_run();
  end
endmodule